// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output compare channel. It watches one of two free-running 16-bit timer counts and drives one output pin from that count. A configuration write sets the timer source and one of eight operating modes. In the single-match modes, one compare value sets, clears or toggles the pin. In the dual-match modes, two compare values bound a pulse, which is produced once or on every timer period. In the PWM modes, the pin rises on the timer's period strobe and falls when the count reaches the duty value.

The channel holds a primary and a secondary compare register. In PWM the secondary register is a shadow: its value becomes the active duty only at a period boundary. This lets the duty change mid-period without a glitch. A sticky event flag records compares, pulse ends, period starts and faults. An active-low fault input can shut the PWM output down and keep it off until the mode is configured again.

The timers and their period strobes come from outside the block. Each period strobe is high for the one cycle in which its timer holds its terminal count.

Top module: `oc_channel`

## Requirements
- R1: After reset the output, the event flag and the fault flag are low, and the mode is disabled (000).
- R2: Timer select 0 uses timer A and its period strobe; timer select 1 uses timer B and its period strobe. Counts from the other timer have no effect.
- R3: In mode 001, 010 and 011, a clock edge in which the selected count equals the primary register drives the output high, drives it low, or toggles it, respectively. The output changes at that edge and an event is raised.
- R4: In mode 100, the output rises on a primary match and falls on a later secondary match. The secondary match wins if both occur in the same cycle. The fall raises an event, and no further pulse follows until the mode is written again.
- R5: In mode 101, the primary/secondary pulse repeats in every timer period.
- R6: In mode 110 and 111, the period strobe drives the output high and raises an event. A primary (duty) match drives it low. The strobe wins if both occur together.
- R7: In the PWM modes the primary register is loaded from the secondary register at each period strobe. A secondary write mid-period therefore takes effect from the next period.
- R8: In mode 111, a low on the fault input drives the output low at the next edge, sets the fault flag and raises an event. Until the mode is written again, the output stays low and the fault flag stays set.
- R9: In mode 110 the fault input is ignored: the output is unaffected and the fault flag stays low.
- R10: The event flag is sticky once set.
- R11: A one-cycle clear strobe lowers the event flag. When an event occurs in the same cycle as the clear, the flag stays set.
- R12: In mode 000 the output is low and no events are raised, whatever the timer counts.
- R13: A configuration write takes effect at the next edge. It clears the fault flag and the pulse-done state. It starts the output high for mode 010 and low for all other modes. Timer matches in the cycle of the write raise no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_a | input | 16 | Count of timer A |
| tmr_b | input | 16 | Count of timer B |
| prd_a | input | 1 | Period strobe of timer A |
| prd_b | input | 1 | Period strobe of timer B |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode to write |
| cfg_tsel | input | 1 | Timer select to write (0 = A, 1 = B) |
| pri_wr | input | 1 | Primary compare register write strobe |
| pri_din | input | 16 | Primary compare write data |
| sec_wr | input | 1 | Secondary compare register write strobe |
| sec_din | input | 16 | Secondary compare write data |
| fault_n | input | 1 | Active-low fault input |
| evt_clr | input | 1 | Event flag clear strobe |
| oc_out | output | 1 | Compare output pin |
| evt_flag | output | 1 | Sticky event flag |
| flt_flag | output | 1 | Fault status flag |

## Verification
The bench runs the two timers at different periods, 20 and 37 counts. Because of this, a compare value that only timer B ever reaches shows which source is in use. Each single-match mode is run against a fixed compare value, and the output is sampled just before and just after the matching edge. This separates a correct edge from a change one cycle early or late. The dual-match modes are run for more than one period, which separates the one-shot pulse from the repeating one. In PWM, the duty is rewritten in the middle of a period: the output must still fall at the old duty in that period and at the new duty in the next one, which shows whether the shadow copy happens at the boundary. The fault input is pulsed both in the mode that honours it and in the mode that must ignore it.

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tmr_a,
  input  logic [W-1:0] tmr_b,
  input  logic         prd_a,
  input  logic         prd_b,
  input  logic         cfg_wr,
  input  logic [2:0]   cfg_mode,
  input  logic         cfg_tsel,
  input  logic         pri_wr,
  input  logic [W-1:0] pri_din,
  input  logic         sec_wr,
  input  logic [W-1:0] sec_din,
  input  logic         fault_n,
  input  logic         evt_clr,
  output logic         oc_out,
  output logic         evt_flag,
  output logic         flt_flag
);
  localparam logic [2:0] M_OFF = 3'd0;
  localparam logic [2:0] M_HI  = 3'd1;
  localparam logic [2:0] M_LO  = 3'd2;
  localparam logic [2:0] M_TG  = 3'd3;
  localparam logic [2:0] M_D1  = 3'd4;
  localparam logic [2:0] M_DN  = 3'd5;
  localparam logic [2:0] M_PW  = 3'd6;
  localparam logic [2:0] M_PF  = 3'd7;

  logic [2:0]   mode_q;
  logic         tsel_q;
  logic         done_q;
  logic [W-1:0] pri_q, sec_q;
  logic         out_nx, evt_set;

  wire [W-1:0] tmr    = tsel_q ? tmr_b : tmr_a;
  wire         prd    = tsel_q ? prd_b : prd_a;
  wire         hit_p  = (tmr == pri_q);
  wire         hit_s  = (tmr == sec_q);
  wire         is_pwm = (mode_q == M_PW) || (mode_q == M_PF);
  wire         flt_hit = (mode_q == M_PF) && !fault_n;

  always_comb begin
    out_nx  = oc_out;
    evt_set = 1'b0;
    case (mode_q)
      M_OFF: out_nx = 1'b0;
      M_HI: if (hit_p) begin out_nx = 1'b1;    evt_set = 1'b1; end
      M_LO: if (hit_p) begin out_nx = 1'b0;    evt_set = 1'b1; end
      M_TG: if (hit_p) begin out_nx = ~oc_out; evt_set = 1'b1; end
      M_D1, M_DN: begin
        if (!done_q) begin
          if (hit_s) begin
            out_nx  = 1'b0;
            evt_set = oc_out;
          end else if (hit_p) begin
            out_nx = 1'b1;
          end
        end
      end
      default: begin
        if (flt_flag || flt_hit) begin
          out_nx  = 1'b0;
          evt_set = flt_hit && !flt_flag;
        end else if (prd) begin
          out_nx  = 1'b1;
          evt_set = 1'b1;
        end else if (hit_p) begin
          out_nx = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_OFF;
      tsel_q   <= 1'b0;
      done_q   <= 1'b0;
      oc_out   <= 1'b0;
      flt_flag <= 1'b0;
      evt_flag <= 1'b0;
    end else begin
      evt_flag <= (evt_set && !cfg_wr) || (evt_flag && !evt_clr);
      if (cfg_wr) begin
        mode_q   <= cfg_mode;
        tsel_q   <= cfg_tsel;
        oc_out   <= (cfg_mode == M_LO);
        flt_flag <= 1'b0;
        done_q   <= 1'b0;
      end else begin
        oc_out <= out_nx;
        if (flt_hit) flt_flag <= 1'b1;
        if (mode_q == M_D1 && hit_s && oc_out) done_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      sec_q <= '0;
    end else begin
      if (pri_wr)                        pri_q <= pri_din;
      else if (is_pwm && prd && !cfg_wr) pri_q <= sec_q;
      if (sec_wr) sec_q <= sec_din;
    end
  end
endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [2:0] cfg_mode,
  input logic [2:0] mode,
  input logic       prd,
  input logic       fault_n,
  input logic       evt_clr,
  input logic       oc_out,
  input logic       evt_flag,
  input logic       flt_flag
);
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !cfg_wr) |=> !oc_out); // R12
  AST_OFF_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !cfg_wr && !evt_flag) |=> !evt_flag); // R12
  AST_CFG_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (oc_out == ($past(cfg_mode) == 3'd2)) && !flt_flag); // R13
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !evt_clr) |=> evt_flag); // R10
  AST_FLT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    flt_flag |-> !oc_out); // R8
  AST_FLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_flag && !cfg_wr) |=> flt_flag); // R8
  AST_NO_FLT_PLAIN_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd6) |-> !flt_flag); // R9
  AST_PWM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b11 && prd && !flt_flag && (fault_n || mode == 3'd6) && !cfg_wr)
      |=> oc_out); // R6
endmodule

bind oc_channel oc_channel_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
  .mode(mode_q), .prd(prd), .fault_n(fault_n), .evt_clr(evt_clr),
  .oc_out(oc_out), .evt_flag(evt_flag), .flt_flag(flt_flag)
);

// File: tb/test_oc_channel.sv
`timescale 1ns/1ps
module test_oc_channel;
  localparam logic [15:0] PA = 16'd19;
  localparam logic [15:0] PB = 16'd36;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] tmr_a, tmr_b, pri_din = '0, sec_din = '0;
  logic prd_a, prd_b;
  logic cfg_wr = 0, cfg_tsel = 0, pri_wr = 0, sec_wr = 0, fault_n = 1, evt_clr = 0;
  logic [2:0] cfg_mode = '0;
  logic oc_out, evt_flag, flt_flag;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  oc_channel i_oc_channel (
    .clk(clk), .rst_n(rst_n), .tmr_a(tmr_a), .tmr_b(tmr_b), .prd_a(prd_a), .prd_b(prd_b),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_tsel(cfg_tsel),
    .pri_wr(pri_wr), .pri_din(pri_din), .sec_wr(sec_wr), .sec_din(sec_din),
    .fault_n(fault_n), .evt_clr(evt_clr),
    .oc_out(oc_out), .evt_flag(evt_flag), .flt_flag(flt_flag)
  );

  initial begin
    tmr_a = '0; tmr_b = '0; prd_a = 0; prd_b = 0;
    forever begin
      @(posedge clk); #1;
      tmr_a = (tmr_a == PA) ? 16'd0 : tmr_a + 16'd1;
      tmr_b = (tmr_b == PB) ? 16'd0 : tmr_b + 16'd1;
      prd_a = (tmr_a == PA);
      prd_b = (tmr_b == PB);
    end
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg(input logic [2:0] m, input logic s);
    cfg_wr = 1; cfg_mode = m; cfg_tsel = s;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic set_pri(input logic [15:0] v);
    pri_wr = 1; pri_din = v; @(negedge clk); pri_wr = 0;
  endtask

  task automatic set_sec(input logic [15:0] v);
    sec_wr = 1; sec_din = v; @(negedge clk); sec_wr = 0;
  endtask

  task automatic clr_evt;
    evt_clr = 1; @(negedge clk); evt_clr = 0;
  endtask

  task automatic wait_a(input logic [15:0] v);
    while (tmr_a != v) @(negedge clk);
  endtask

  task automatic wait_b(input logic [15:0] v);
    while (tmr_b != v) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(oc_out, 0, "R1 output after reset");
    chk(evt_flag, 0, "R1 event after reset");
    chk(flt_flag, 0, "R1 fault after reset");
  endtask

  task automatic t_single_high;
    set_pri(16'd5);
    cfg(3'd1, 0);
    chk(oc_out, 0, "R13 mode 001 starts low");
    wait_a(16'd5);
    chk(oc_out, 0, "R3 no change before match edge");
    @(negedge clk);
    chk(oc_out, 1, "R3 mode 001 high after match");
    chk(evt_flag, 1, "R10 event on match");
    tick(3);
    chk(oc_out, 1, "R3 mode 001 stays high");
  endtask

  task automatic t_evt_clear;
    clr_evt;
    chk(evt_flag, 0, "R11 clear strobe lowers flag");
    cfg(3'd3, 0);
    chk(evt_flag, 0, "R13 no event on config write");
    wait_a(16'd5);
    evt_clr = 1; @(negedge clk); evt_clr = 0;
    chk(evt_flag, 1, "R11 event wins over clear");
    chk(oc_out, 1, "R3 toggle first match");
    tick(1);
    wait_a(16'd5);
    @(negedge clk);
    chk(oc_out, 0, "R3 toggle second match");
  endtask

  task automatic t_single_low;
    cfg(3'd2, 0);
    chk(oc_out, 1, "R13 mode 010 starts high");
    wait_a(16'd5);
    @(negedge clk);
    chk(oc_out, 0, "R3 mode 010 low after match");
  endtask

  task automatic t_tsel;
    logic seen = 0;
    set_pri(16'd30);
    cfg(3'd1, 0);
    for (int i = 0; i < 45; i++) begin @(negedge clk); seen |= oc_out; end
    chk(seen, 0, "R2 timer A never reaches 30");
    cfg(3'd1, 1);
    wait_b(16'd30);
    chk(oc_out, 0, "R2 timer B before match");
    @(negedge clk);
    chk(oc_out, 1, "R2 timer B match drives high");
  endtask

  task automatic t_dual_one;
    set_pri(16'd4); set_sec(16'd9);
    cfg(3'd4, 0);
    clr_evt;
    wait_a(16'd4); @(negedge clk);
    chk(oc_out, 1, "R4 rise on primary match");
    wait_a(16'd9);
    chk(oc_out, 1, "R4 high up to secondary match");
    @(negedge clk);
    chk(oc_out, 0, "R4 fall on secondary match");
    chk(evt_flag, 1, "R10 event on pulse end");
    wait_a(16'd4); @(negedge clk);
    chk(oc_out, 0, "R4 only one pulse");
  endtask

  task automatic t_dual_cont;
    cfg(3'd5, 0);
    wait_a(16'd4); @(negedge clk);
    chk(oc_out, 1, "R5 first pulse rise");
    wait_a(16'd9); @(negedge clk);
    chk(oc_out, 0, "R5 first pulse fall");
    wait_a(16'd4); @(negedge clk);
    chk(oc_out, 1, "R5 second pulse rise");
  endtask

  task automatic t_pwm;
    set_pri(16'd6); set_sec(16'd6);
    cfg(3'd6, 0);
    clr_evt;
    wait_a(PA); @(negedge clk);
    chk(oc_out, 1, "R6 rise after period strobe");
    chk(evt_flag, 1, "R10 event on period");
    set_sec(16'd10);
    wait_a(16'd6);
    chk(oc_out, 1, "R6 high before duty match");
    @(negedge clk);
    chk(oc_out, 0, "R7 old duty kept this period");
    wait_a(PA); @(negedge clk);
    chk(oc_out, 1, "R6 rise next period");
    wait_a(16'd6); @(negedge clk);
    chk(oc_out, 1, "R7 new duty not yet reached");
    wait_a(16'd10); @(negedge clk);
    chk(oc_out, 0, "R7 fall at new duty");
  endtask

  task automatic t_fault;
    cfg(3'd7, 0);
    wait_a(PA); @(negedge clk);
    chk(oc_out, 1, "R6 mode 111 rise");
    clr_evt;
    fault_n = 0; @(negedge clk); fault_n = 1;
    chk(oc_out, 0, "R8 fault forces low");
    chk(flt_flag, 1, "R8 fault flag set");
    chk(evt_flag, 1, "R8 fault raises event");
    wait_a(PA); @(negedge clk); @(negedge clk);
    chk(oc_out, 0, "R8 held low past period");
    chk(flt_flag, 1, "R8 fault flag held");
    cfg(3'd7, 0);
    chk(flt_flag, 0, "R13 config write clears fault");
    cfg(3'd6, 0);
    wait_a(PA); @(negedge clk);
    fault_n = 0; @(negedge clk); fault_n = 1;
    chk(oc_out, 1, "R9 fault ignored in 110");
    chk(flt_flag, 0, "R9 no fault flag in 110");
  endtask

  task automatic t_off;
    set_pri(16'd3);
    cfg(3'd0, 0);
    clr_evt;
    tick(45);
    chk(oc_out, 0, "R12 disabled output low");
    chk(evt_flag, 0, "R12 disabled raises no event");
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset;
    t_single_high;
    t_evt_clear;
    t_single_low;
    t_tsel;
    t_dual_one;
    t_dual_cont;
    t_pwm;
    t_fault;
    t_off;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule